// File: doc/BRIEF.md
# HyperRAM Configuration Register Sequencer

This block reads and writes the 16-bit configuration registers of a HyperRAM device over its 8-bit double-data-rate bus. Each data transition takes one system clock. A client raises a one-cycle request and supplies a 48-bit command/address word, a direction flag and, for a write, the 16-bit register value. The block then pulls chip select low, drives the command/address bytes while it toggles the device clock, and either sends the two register bytes or releases the bus and waits for the device to answer.

Read data is not captured on the device's read strobe. The block samples it at a point set by a capture delay code. The upper bits of the code give a wait in system clocks. The least significant bit chooses whether the data pins are sampled directly (1) or through an input register (0), which moves the sample point by a fraction of a cycle. Because the device's clock stops after the second answer byte, that byte stays on the bus and the second sample can follow the first one system clock later.

After reset the block holds off every access until a programmable power-up interval has passed. An access made earlier would return garbage. A busy flag covers that interval and every transaction. A one-cycle done pulse marks the end of each access and carries the read result.

Top module: `hr_reg_seq`

## Requirements
- R1: After reset release, `busy` stays high and `hr_cs_n` stays high for RST_CYC clock edges, and requests are ignored. `busy` is first seen low after edge RST_CYC+1.
- R2: A write (req_write=1) drives 8 clock transitions with chip select low. The byte present before each transition is, in order, req_ca from bits 47:40 down to bits 7:0, then req_wdata[15:8], then req_wdata[7:0].
- R3: A read (req_write=0) drives exactly 30 clock transitions with chip select low. The first 6 of them carry the command/address bytes, most significant byte first.
- R4: On a read, `hr_dq_oe` is high through the 5th transition. It falls on the same edge as the 6th transition and stays low until the end of the transaction.
- R5: For cap_code, let W = cap_code[5:1]. If cap_code[0]=1, the first sample is the bus value after transition 6+W; if cap_code[0]=0, it is the value after transition 5+W. Transition counts are capped at 30.
- R6: The first read byte lands in rdata[15:8] and the second in rdata[7:0]. Bits 31:16 are zero. After a write, rdata is zero.
- R7: The second read sample is taken one system clock after the first, so it is the bus value one transition later (capped at 30).
- R8: If a request is accepted at edge 0, `done` is high for exactly one cycle after edge E, where E=9 for a write and E=max(30, 8+W)+1 for a read. In that cycle chip select is high and `busy` is low.
- R9: A request made while `busy` is high is ignored. It changes neither the bytes sent nor the length of the transaction, and no second transaction follows.
- R10: The device clock `hr_ck` is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle access request, accepted when not busy |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_ca | input | 48 | Command/address word, sent most significant byte first |
| req_wdata | input | 16 | Register value for a write |
| cap_code | input | 6 | Read capture delay: [5:1] wait in clocks, [0] unregistered sampling |
| busy | output | 1 | High during the power-up wait and during a transaction |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdata | output | 32 | Read result, valid in the done cycle |
| hr_cs_n | output | 1 | Device chip select, active low |
| hr_ck | output | 1 | Device clock, one transition per active system clock |
| hr_dq_out | output | 8 | Data bus output value |
| hr_dq_oe | output | 1 | Data bus output enable |
| hr_dq_in | input | 8 | Data bus input value |

## Verification
Take the accepting edge as edge 0. The k-th clock transition happens at edge k, and the byte launched at edge k-1 is the one on the bus before it. Done follows at edge 9 for a write and at edge max(30, 8+W)+1 for a read, and the bus release comes at edge 6. The bench samples the outputs on the falling clock after each rising edge and counts which edge that is. It pairs each observed transition with the byte seen on the previous falling edge. A device model in the bench answers by transition count, and the bench works out the expected read result from the transition index each sampling mode should see.

// File: rtl/hr_reg_pkg.sv
// Shared types for the HyperRAM configuration register sequencer.
package hr_reg_pkg;
    // Sequencer phase: power-up wait, ready for a request, access running.
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_IDLE = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/hr_rst_timer.sv
// Power-up interval timer. After reset it counts RST_CYC system clocks and
// then raises ready, which stays high until the next reset.
// Assumes RST_CYC >= 2.
module hr_rst_timer #(
    parameter int RST_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    localparam int CW = $clog2(RST_CYC + 1);

    logic [CW-1:0] cnt;

    // Count the power-up interval once and then hold ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else if (!ready) begin
            if (cnt == CW'(RST_CYC - 1)) ready <= 1'b1;
            else                         cnt   <= cnt + 1'b1;
        end
    end

    // Once the interval has passed it never reopens without reset.
    p_ready_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
endmodule

// File: rtl/hr_ck_train.sv
// Device clock generator. On start it loads a transition count. It then
// toggles the clock once per system clock until that many transitions have
// been made, and leaves the clock where it ended (low, for even counts).
module hr_ck_train #(
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] lim_in,
    output logic          ck,
    output logic [TW-1:0] tcnt,
    output logic          train_done
);
    logic [TW-1:0] lim_q;

    // Reload on start, otherwise toggle until the transition budget is spent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck    <= 1'b0;
            tcnt  <= '0;
            lim_q <= '0;
        end else if (start) begin
            ck    <= 1'b0;
            tcnt  <= '0;
            lim_q <= lim_in;
        end else if (tcnt != lim_q) begin
            ck   <= ~ck;
            tcnt <= tcnt + 1'b1;
        end
    end

    assign train_done = (tcnt == lim_q);

    // The transition count never overshoots its budget.
    p_tcnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tcnt <= lim_q);
    // A finished train stays still until the next start.
    p_ck_parked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (train_done && !start) |=> $stable(ck));
endmodule

// File: rtl/hr_rd_capture.sv
// Read data capture. It counts system clocks from the accepting edge. The
// first sample is taken at clock CA_TRANS + code[CODE_W-1:1], and the
// following bytes one clock apart. code[0] = 1 samples the pins directly;
// code[0] = 0 samples them through an input register, one cycle older.
// Assumes the device holds its last byte once its clock stops.
module hr_rd_capture #(
    parameter int BYTE_W   = 8,
    parameter int NBYTES   = 2,
    parameter int CODE_W   = 6,
    parameter int CA_TRANS = 6,
    parameter int CNT_W    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     skip,
    input  logic [CODE_W-1:0]        code,
    input  logic [BYTE_W-1:0]        dq_in,
    output logic                     cap_done,
    output logic [NBYTES*BYTE_W-1:0] rbuf
);
    localparam int WAIT_W = CODE_W - 1;

    logic [CNT_W-1:0]  cnt;
    logic [WAIT_W-1:0] wait_q;
    logic              unreg_q;
    logic [BYTE_W-1:0] in_q;
    logic [CNT_W-1:0]  first_idx;
    logic [CNT_W-1:0]  last_idx;
    logic              in_win;
    logic [BYTE_W-1:0] sample;

    // Input register stage of the registered sampling path.
    always_ff @(posedge clk) begin
        if (!rst_n) in_q <= '0;
        else        in_q <= dq_in;
    end

    // Sampling window and source selection.
    always_comb begin
        first_idx = CNT_W'(CA_TRANS) + CNT_W'(wait_q);
        last_idx  = first_idx + CNT_W'(NBYTES - 1);
        in_win    = (cnt >= first_idx) && (cnt <= last_idx);
        sample    = unreg_q ? dq_in : in_q;
    end

    // Latch the code at start, then count and shift in bytes, first byte highest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            wait_q   <= '0;
            unreg_q  <= 1'b0;
            cap_done <= 1'b0;
            rbuf     <= '0;
        end else if (start) begin
            cnt      <= '0;
            wait_q   <= code[CODE_W-1:1];
            unreg_q  <= code[0];
            cap_done <= skip;
            rbuf     <= '0;
        end else if (!cap_done) begin
            cnt <= cnt + 1'b1;
            if (in_win) rbuf <= {rbuf[(NBYTES-1)*BYTE_W-1:0], sample};
            if (cnt == last_idx) cap_done <= 1'b1;
        end
    end

    // Captured bytes stay put until the next access starts.
    p_rbuf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_done && !start) |=> $stable(rbuf));
    // Capture can only finish in the last cycle of its window.
    p_cap_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_done) |-> ($past(cnt) == $past(last_idx)) || $past(start));
endmodule

// File: rtl/hr_reg_seq.sv
// HyperRAM configuration register sequencer, top level. It waits out the
// power-up interval, then accepts one register read or write at a time.
// It frames the access with chip select, launches one bus byte per system
// clock ahead of each clock transition, releases the bus after the
// command/address phase of a read, and reports with a one-cycle done pulse.
// Assumes RD_W is wider than the register and the device answers in the
// last two transitions of the read clock train.
module hr_reg_seq
    import hr_reg_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int CA_BYTES  = 6,
    parameter int REG_BYTES = 2,
    parameter int LAT_CYC   = 12,
    parameter int CODE_W    = 6,
    parameter int RD_W      = 32,
    parameter int RST_CYC   = 200
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [CA_BYTES*BYTE_W-1:0]    req_ca,
    input  logic [REG_BYTES*BYTE_W-1:0]   req_wdata,
    input  logic [CODE_W-1:0]             cap_code,
    output logic                          busy,
    output logic                          done,
    output logic [RD_W-1:0]               rdata,
    output logic                          hr_cs_n,
    output logic                          hr_ck,
    output logic [BYTE_W-1:0]             hr_dq_out,
    output logic                          hr_dq_oe,
    input  logic [BYTE_W-1:0]             hr_dq_in
);
    localparam int CA_W     = CA_BYTES * BYTE_W;
    localparam int REG_W    = REG_BYTES * BYTE_W;
    localparam int BUF_W    = CA_W + REG_W;
    localparam int CA_TRANS = CA_BYTES;
    localparam int WR_TRANS = CA_BYTES + REG_BYTES;
    // Latency starts counting two transitions before the end of the CA phase.
    localparam int RD_TRANS = CA_BYTES - 2 + 2 * LAT_CYC + REG_BYTES;
    localparam int TW       = $clog2(RD_TRANS + 1);
    localparam int CNT_W    = $clog2(CA_TRANS + REG_BYTES + (1 << (CODE_W - 1)) + 1) + 1;

    seq_state_t        state;
    logic              is_wr;
    logic [BUF_W-1:0]  obuf;
    logic              ready;
    logic              accept;
    logic              fin;
    logic [TW-1:0]     lim_sel;
    logic [TW-1:0]     tcnt;
    logic              train_done;
    logic [CODE_W-1:0] code_sel;
    logic              cap_done;
    logic [REG_W-1:0]  rbuf;

    hr_rst_timer #(.RST_CYC(RST_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (ready)
    );

    hr_ck_train #(.TW(TW)) u_train (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .lim_in     (lim_sel),
        .ck         (hr_ck),
        .tcnt       (tcnt),
        .train_done (train_done)
    );

    hr_rd_capture #(
        .BYTE_W   (BYTE_W),
        .NBYTES   (REG_BYTES),
        .CODE_W   (CODE_W),
        .CA_TRANS (CA_TRANS),
        .CNT_W    (CNT_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .skip     (req_write),
        .code     (code_sel),
        .dq_in    (hr_dq_in),
        .cap_done (cap_done),
        .rbuf     (rbuf)
    );

    // Request acceptance, end detection and per-direction settings.
    always_comb begin
        accept   = (state == ST_IDLE) && req_valid;
        fin      = (state == ST_RUN) && train_done && cap_done;
        lim_sel  = req_write ? TW'(WR_TRANS) : TW'(RD_TRANS);
        code_sel = req_write ? '0 : cap_code;
    end

    // Transaction framing: chip select, byte launch and bus direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_WAIT;
            is_wr    <= 1'b0;
            obuf     <= '0;
            hr_cs_n  <= 1'b1;
            hr_dq_oe <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_WAIT: if (ready) state <= ST_IDLE;
                ST_IDLE: if (accept) begin
                    state    <= ST_RUN;
                    is_wr    <= req_write;
                    obuf     <= {req_ca, req_write ? req_wdata : REG_W'(0)};
                    hr_cs_n  <= 1'b0;
                    hr_dq_oe <= 1'b1;
                end
                ST_RUN: begin
                    obuf <= obuf << BYTE_W;
                    if (!is_wr && tcnt == TW'(CA_TRANS - 1)) hr_dq_oe <= 1'b0;
                    if (fin) begin
                        state    <= ST_IDLE;
                        hr_cs_n  <= 1'b1;
                        hr_dq_oe <= 1'b0;
                        done     <= 1'b1;
                    end
                end
                default: state <= ST_WAIT;
            endcase
        end
    end

    assign hr_dq_out = obuf[BUF_W-1 -: BYTE_W];
    assign busy      = (state != ST_IDLE);
    assign rdata     = {{(RD_W - REG_W){1'b0}}, rbuf};

    // No bus activity during the power-up wait.
    p_wait_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> hr_cs_n);
    // Clock rests low outside a transaction.
    p_ck_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hr_cs_n |-> !hr_ck);
    // The bus is only driven inside a transaction.
    p_oe_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hr_dq_oe |-> !hr_cs_n);
    // A read has released the bus once the CA transitions are done.
    p_rd_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !is_wr && tcnt >= TW'(CA_TRANS)) |-> !hr_dq_oe);
    // Write length.
    p_wr_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && is_wr) |-> (tcnt == TW'(WR_TRANS)));
    // Read length.
    p_rd_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !is_wr) |-> (tcnt == TW'(RD_TRANS)));
    // Done is a single-cycle pulse.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // Done coincides with a closed frame and a free block.
    p_done_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (hr_cs_n && !busy));
    // A running access is not cut short by anything but its own end.
    p_run_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !fin) |=> (state == ST_RUN && !hr_cs_n));
endmodule

// File: tb/hr_reg_seq_bench.sv
// Self-checking bench for hr_reg_seq with a behavioural device that answers
// by counting clock transitions inside chip select.
module hr_reg_seq_bench;
    localparam int RST  = 200;
    localparam int JUNK = 8'hEE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [47:0] req_ca = '0;
    logic [15:0] req_wdata = '0;
    logic [5:0]  cap_code = '0;
    logic        busy, done, hr_cs_n, hr_ck, hr_dq_oe;
    logic [31:0] rdata;
    logic [7:0]  hr_dq_out, hr_dq_in;

    int checks = 0;
    int errors = 0;

    logic [7:0] dev_b1 = 8'h00;
    logic [7:0] dev_b2 = 8'h00;
    int         dev_t  = 0;

    always #10 clk = ~clk;

    hr_reg_seq #(.RST_CYC(RST)) u_hr_reg_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_ca(req_ca), .req_wdata(req_wdata), .cap_code(cap_code),
        .busy(busy), .done(done), .rdata(rdata), .hr_cs_n(hr_cs_n),
        .hr_ck(hr_ck), .hr_dq_out(hr_dq_out), .hr_dq_oe(hr_dq_oe),
        .hr_dq_in(hr_dq_in)
    );

    // Device model: counts transitions within a frame, answers in the last two.
    always @(hr_ck) if (hr_cs_n === 1'b0) dev_t = dev_t + 1;
    always @(posedge hr_cs_n) dev_t = 0;
    assign hr_dq_in = (dev_t < 28) ? 8'(JUNK) : ((dev_t == 28) ? dev_b1 : dev_b2);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] bus_at(int t, logic [7:0] b1, logic [7:0] b2);
        int tc = (t > 30) ? 30 : t;
        if (tc < 28)  return 8'(JUNK);
        if (tc == 28) return b1;
        return b2;
    endfunction

    // R5/R6/R7: expected read result from the transition index each sample sees.
    function automatic logic [31:0] exp_rd(logic [5:0] code, logic [7:0] b1, logic [7:0] b2);
        int t1 = 5 + int'(code[5:1]) + int'(code[0]);
        return {16'h0, bus_at(t1, b1, b2), bus_at(t1 + 1, b1, b2)};
    endfunction

    function automatic int exp_end(bit wr, logic [5:0] code);
        int w = int'(code[5:1]);
        if (wr) return 9;
        return ((30 > 8 + w) ? 30 : 8 + w) + 1;
    endfunction

    task automatic run_txn(input bit wr, input logic [47:0] ca, input logic [15:0] wd,
                           input logic [5:0] code, input logic [7:0] b1,
                           input logic [7:0] b2, input bit inject);
        logic [7:0] seen [0:39];
        logic       pck, poe5, poe6;
        logic [7:0] pdq;
        int         ntog = 0;
        int         endk = -1;
        bit         cs_bad = 0;
        bit         byte_bad = 0;
        logic [31:0] got;
        string      rtag = wr ? "R2" : "R3";
        @(negedge clk);
        dev_b1 = b1; dev_b2 = b2;
        req_valid = 1'b1; req_write = wr; req_ca = ca; req_wdata = wd; cap_code = code;
        pck = hr_ck; pdq = hr_dq_out; poe5 = 1'b0; poe6 = 1'b1;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (k == 0) req_valid = 1'b0;
            if (inject && k == 2) begin
                req_valid = 1'b1; req_write = 1'b1; req_ca = ~ca; req_wdata = ~wd;
            end
            if (inject && k == 3) req_valid = 1'b0;
            if (hr_ck !== pck && ntog < 40) begin
                seen[ntog] = pdq;
                ntog++;
            end
            if (k == 5) poe5 = hr_dq_oe;
            if (k == 6) poe6 = hr_dq_oe;
            if (done) begin
                endk = k;
                break;
            end
            if (hr_cs_n) cs_bad = 1;
            pck = hr_ck; pdq = hr_dq_out;
        end
        got = rdata;
        chk(endk == exp_end(wr, code), "R8 done edge", 64'(endk), 64'(exp_end(wr, code)));
        chk(ntog == (wr ? 8 : 30), {rtag, " transition count"}, 64'(ntog), 64'(wr ? 8 : 30));
        chk(!cs_bad, {rtag, " cs low through frame"}, 64'(cs_bad), 0);
        for (int i = 0; i < 6; i++)
            if (i < ntog && seen[i] !== ca[47 - 8*i -: 8]) byte_bad = 1;
        chk(!byte_bad, inject ? "R9 CA bytes unchanged by late request" : {rtag, " CA bytes"},
            64'(byte_bad), 0);
        if (wr) begin
            chk(ntog >= 8 && seen[6] === wd[15:8] && seen[7] === wd[7:0], "R2 data bytes MSB first",
                {seen[6], seen[7]}, wd);
            chk(got === 32'h0, "R6 rdata after write", got, 0);
        end else begin
            chk(poe5 === 1'b1 && poe6 === 1'b0, "R4 bus release at 6th transition",
                {poe5, poe6}, 2'b10);
            chk(got === exp_rd(code, b1, b2), "R5 R6 R7 read data", got, exp_rd(code, b1, b2));
        end
        @(negedge clk);
        chk(!done && hr_cs_n && !hr_ck, "R8 R10 done pulse width and idle clock",
            {done, hr_cs_n, hr_ck}, 3'b010);
        cs_bad = 0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            if (!hr_cs_n) cs_bad = 1;
        end
        chk(!cs_bad, "R9 no follow-on transaction", 64'(cs_bad), 0);
    endtask

    initial begin
        #(20 * 200000);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit early_cs = 0;
        bit junk;
        junk = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        chk(busy && hr_cs_n && !hr_ck && !done && !hr_dq_oe, "R1 reset state",
            {busy, hr_cs_n, hr_ck, done, hr_dq_oe}, 5'b11000);
        rst_n = 1'b1;
        for (int i = 1; i <= RST + 1; i++) begin
            @(negedge clk);
            if (i == 5) begin req_valid = 1'b1; req_write = 1'b1; end
            if (i == 6) req_valid = 1'b0;
            if (!hr_cs_n) early_cs = 1;
            if (i == RST) chk(busy === 1'b1, "R1 busy through wait", busy, 1);
            if (i == RST + 1) chk(busy === 1'b0, "R1 busy falls", busy, 0);
        end
        chk(!early_cs, "R1 request ignored during wait", 64'(early_cs), 0);

        // Directed corner cases.
        run_txn(1, 48'h600000000001, 16'h8F1F, 6'd0, 8'h00, 8'h00, 0);
        run_txn(0, 48'hE00000000001, 16'h0, 6'd46, 8'hA5, 8'h3C, 0); // registered, exact fit
        run_txn(0, 48'hE00000000001, 16'h0, 6'd45, 8'h5A, 8'hC3, 0); // unregistered, exact fit
        run_txn(0, 48'hE00000000000, 16'h0, 6'd44, 8'h12, 8'h34, 0); // one early
        run_txn(0, 48'hE00000000000, 16'h0, 6'd0,  8'h12, 8'h34, 0); // far too early
        run_txn(0, 48'hE00000000000, 16'h0, 6'd63, 8'h77, 8'h99, 0); // late, end stretched
        run_txn(0, 48'hC1C2C3C4C5C6, 16'h0, 6'd47, 8'h9F, 8'hFF, 1); // late request ignored
        run_txn(1, 48'h0102030405A6, 16'hFF9F, 6'd7, 8'h00, 8'h00, 1);

        // Constrained random mix.
        for (int n = 0; n < 40; n++) begin
            bit wr = $urandom_range(0, 2) == 0;
            logic [5:0] code = (n % 3 == 0) ? 6'($urandom_range(44, 47)) : 6'($urandom_range(0, 63));
            run_txn(wr, {16'($urandom), 32'($urandom)}, 16'($urandom), code,
                    8'($urandom), 8'($urandom), n % 7 == 3);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule